// File: doc/BRIEF.md
# Running-Count Index Vector Generator

The block turns three scalar operands (a bit mask, a requested vector length and a stride) into a stream of vector elements. Element `i` equals the stride times the number of set mask bits at positions strictly before `i`. The resulting sequence is the value that a conditionally incremented induction variable holds in each iteration of a loop. That makes the stream a ready-made index vector for vectorizing expansion loops, where a source array is read only on iterations whose condition holds and every iteration receives the most recent value.

A single-cycle `start` pulse loads the operands while the block is idle. From the next cycle onward one element appears per clock, for exactly the requested number of cycles. The final element carries `out_last`, and in that same cycle `out_total` shows how many of the covered mask bits were set. The mask's most significant bit belongs to element 0. A length of zero yields nothing. A length greater than the mask width is cut down to the mask width.

Top module: `ciota_gen`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `busy` are low and `out_total` is zero.
- R2: A `start` accepted while idle with effective length L ≥ 1 raises `out_valid` in the following cycle and keeps it high for exactly L consecutive cycles. `out_last` is high only in the L-th of those cycles.
- R3: Element i (counting from 0 in order of output) equals stride × (the number of set bits among mask bits MASK_W-1 down to MASK_W-i). Mask bit MASK_W-1 is position 0. The value is truncated to ELEM_W bits.
- R4: The first element of every run is zero, whatever the mask and stride.
- R5: A `start` with a requested length of 0 produces no element, and `busy` stays low.
- R6: A requested length above MASK_W is treated as MASK_W, so a run never exceeds MASK_W elements.
- R7: In the cycle where `out_last` is high, `out_total` equals the number of set bits among the first L mask positions. In every other cycle it is zero.
- R8: A `start` that arrives while `busy` is high is ignored, including one in the last cycle of a run. The current run's elements, length and total stay unchanged, and no second run follows.
- R9: Within a run, each element equals the previous element plus the stride when the previous position's mask bit is set, and equals the previous element otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operand load request, honoured only while idle |
| mask_in | input | MASK_W | Condition mask; MSB maps to element 0 |
| len_in | input | LEN_IN_W | Requested element count |
| stride_in | input | STRIDE_W | Unsigned stride added per set mask bit |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | `out_data` holds an element this cycle |
| out_last | output | 1 | Current element is the final one of the run |
| out_data | output | ELEM_W | Running count times stride |
| out_total | output | CNT_W | Set-bit count over the run, shown with `out_last` |

## Verification
The checker watches every cycle for the stepping law between adjacent elements, a zero first element, a run that never outlasts the mask width, a total that stays zero away from the last element, a valid that follows an accepted start, and a busy run that a competing start cannot interrupt. The absolute value of each element for a given mask, the exact run length after clamping, and the agreement of the reported total with the mask can only be shown by the bench's scenarios, which compare them against counts computed independently from the operands. The same holds for a mid-run start leaving no trace.

// File: rtl/ciota_pkg.sv
package ciota_pkg;

  // Default geometry shared by the block and its bench.
  localparam int unsigned CI_MASK_W   = 64;
  localparam int unsigned CI_LEN_IN_W = 8;
  localparam int unsigned CI_STRIDE_W = 16;

  // Run controller states.
  typedef enum logic [0:0] {
    RUN_IDLE = 1'b0,
    RUN_EMIT = 1'b1
  } run_state_e;

endpackage

// File: rtl/ciota_ctrl.sv
module ciota_ctrl
  import ciota_pkg::*;
#(
  parameter int unsigned MASK_W   = CI_MASK_W,
  parameter int unsigned LEN_IN_W = CI_LEN_IN_W,
  parameter int unsigned CNT_W    = $clog2(MASK_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_IN_W-1:0] len_req,
  output logic                load,
  output logic                step,
  output logic                last,
  output logic                busy
);

  // Clamp the requested length to the mask width.
  function automatic logic [CNT_W-1:0] clamp_len(input logic [LEN_IN_W-1:0] req);
    if (int'(req) > int'(MASK_W)) return CNT_W'(MASK_W);
    return CNT_W'(req);
  endfunction

  run_state_e       state_q;
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] eff_len;

  assign eff_len = clamp_len(len_req);
  assign busy    = (state_q == RUN_EMIT);
  assign load    = start && !busy && (eff_len != '0);
  assign step    = busy;
  assign last    = busy && (remain_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RUN_IDLE;
      remain_q <= '0;
    end else if (load) begin
      state_q  <= RUN_EMIT;
      remain_q <= eff_len;
    end else if (busy) begin
      remain_q <= remain_q - CNT_W'(1);
      if (last) state_q <= RUN_IDLE;
    end
  end

endmodule

// File: rtl/ciota_mask_shift.sv
module ciota_mask_shift #(
  parameter int unsigned MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [MASK_W-1:0] mask_in,
  output logic              cur_bit
);

  logic [MASK_W-1:0] sh_q;

  // Position 0 sits at the MSB; each step exposes the next position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= mask_in;
    end else if (step) begin
      sh_q <= {sh_q[MASK_W-2:0], 1'b0};
    end
  end

  assign cur_bit = sh_q[MASK_W-1];

endmodule

// File: rtl/ciota_accum.sv
module ciota_accum #(
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned ELEM_W   = STRIDE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                cur_bit,
  input  logic [STRIDE_W-1:0] stride_in,
  output logic [ELEM_W-1:0]   elem,
  output logic [CNT_W-1:0]    count,
  output logic [STRIDE_W-1:0] stride_q
);

  // One adder: the stride is added only after a set position is emitted.
  function automatic logic [ELEM_W-1:0] next_elem(
    input logic [ELEM_W-1:0]   acc,
    input logic                hit,
    input logic [STRIDE_W-1:0] stride
  );
    return hit ? acc + ELEM_W'(stride) : acc;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cnt,
    input logic             hit
  );
    return cnt + CNT_W'(hit);
  endfunction

  logic [ELEM_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      stride_q <= '0;
    end else if (load) begin
      acc_q    <= '0;
      cnt_q    <= '0;
      stride_q <= stride_in;
    end else if (step) begin
      acc_q <= next_elem(acc_q, cur_bit, stride_q);
      cnt_q <= next_count(cnt_q, cur_bit);
    end
  end

  assign elem  = acc_q;
  assign count = cnt_q;

endmodule

// File: rtl/ciota_gen.sv
module ciota_gen
  import ciota_pkg::*;
#(
  parameter int unsigned MASK_W   = CI_MASK_W,
  parameter int unsigned LEN_IN_W = CI_LEN_IN_W,
  parameter int unsigned STRIDE_W = CI_STRIDE_W,
  localparam int unsigned CNT_W   = $clog2(MASK_W + 1),
  localparam int unsigned ELEM_W  = STRIDE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [MASK_W-1:0]   mask_in,
  input  logic [LEN_IN_W-1:0] len_in,
  input  logic [STRIDE_W-1:0] stride_in,
  output logic                busy,
  output logic                out_valid,
  output logic                out_last,
  output logic [ELEM_W-1:0]   out_data,
  output logic [CNT_W-1:0]    out_total
);

  // Internal events, named for the bound checker.
  logic                load;
  logic                step;
  logic                last;
  logic                cur_bit;
  logic [CNT_W-1:0]    count;
  logic [STRIDE_W-1:0] stride_q;
  logic [ELEM_W-1:0]   elem;

  ciota_ctrl #(
    .MASK_W  (MASK_W),
    .LEN_IN_W(LEN_IN_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .len_req(len_in),
    .load   (load),
    .step   (step),
    .last   (last),
    .busy   (busy)
  );

  ciota_mask_shift #(
    .MASK_W(MASK_W)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .mask_in(mask_in),
    .cur_bit(cur_bit)
  );

  ciota_accum #(
    .STRIDE_W(STRIDE_W),
    .CNT_W   (CNT_W),
    .ELEM_W  (ELEM_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .cur_bit  (cur_bit),
    .stride_in(stride_in),
    .elem     (elem),
    .count    (count),
    .stride_q (stride_q)
  );

  assign out_valid = step;
  assign out_last  = last;
  assign out_data  = elem;
  assign out_total = last ? count + CNT_W'(cur_bit) : '0;

endmodule

// File: rtl/ciota_chk.sv
module ciota_chk #(
  parameter int unsigned MASK_W   = 64,
  parameter int unsigned LEN_IN_W = 8,
  parameter int unsigned STRIDE_W = 16,
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned ELEM_W   = 23
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [LEN_IN_W-1:0] len_in,
  input logic                busy,
  input logic                out_valid,
  input logic                out_last,
  input logic [ELEM_W-1:0]   out_data,
  input logic [CNT_W-1:0]    out_total,
  input logic                cur_bit,
  input logic [STRIDE_W-1:0] stride_q
);

  // Elements already seen in the current run.
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (out_valid) run_cnt <= run_cnt + CNT_W'(1);
    else                run_cnt <= '0;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_in != '0) |=> out_valid);

  p_last_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  p_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> (out_data == '0));

  p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_in == '0) |=> !out_valid);

  p_run_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_cnt < CNT_W'(MASK_W)));

  p_total_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_last |-> (out_total == '0));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_last) |=> (out_valid && busy));

  p_step_law_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      (out_data == $past(out_data) + ($past(cur_bit) ? ELEM_W'($past(stride_q)) : ELEM_W'(0))));

endmodule

bind ciota_gen ciota_chk #(
  .MASK_W  (MASK_W),
  .LEN_IN_W(LEN_IN_W),
  .STRIDE_W(STRIDE_W),
  .CNT_W   (CNT_W),
  .ELEM_W  (ELEM_W)
) u_ciota_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .len_in   (len_in),
  .busy     (busy),
  .out_valid(out_valid),
  .out_last (out_last),
  .out_data (out_data),
  .out_total(out_total),
  .cur_bit  (cur_bit),
  .stride_q (stride_q)
);

// File: tb/test_ciota_gen.sv
`timescale 1ns/1ps
module test_ciota_gen;
  import ciota_pkg::*;

  localparam int unsigned MW = CI_MASK_W;
  localparam int unsigned LW = CI_LEN_IN_W;
  localparam int unsigned SW = CI_STRIDE_W;
  localparam int unsigned CW = $clog2(MW + 1);
  localparam int unsigned EW = SW + CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [MW-1:0] mask_in = '0;
  logic [LW-1:0] len_in = '0;
  logic [SW-1:0] stride_in = '0;
  logic          busy, out_valid, out_last;
  logic [EW-1:0] out_data;
  logic [CW-1:0] out_total;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ciota_gen i_ciota_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in),
    .len_in(len_in), .stride_in(stride_in), .busy(busy),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
    .out_total(out_total)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected element i: stride times set bits among positions 0..i-1.
  function automatic longint exp_elem(input logic [MW-1:0] m, input int i, input logic [SW-1:0] s);
    longint n = 0;
    for (int k = 0; k < i; k++) if (m[MW-1-k]) n++;
    return (n * longint'(s)) & ((longint'(1) << EW) - 1);
  endfunction

  // Issue a run and check every output cycle. inject >= 0 raises a
  // competing start at that element index (R8).
  task automatic run_case(input string name, input logic [MW-1:0] m,
                          input int req_len, input logic [SW-1:0] s, input int inject);
    int eff = (req_len > int'(MW)) ? int'(MW) : req_len;
    @(negedge clk);
    mask_in = m; len_in = LW'(req_len); stride_in = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (eff == 0) begin
      check({name, " R5 valid"}, out_valid, 0);
      check({name, " R5 busy"}, busy, 0);
      @(negedge clk);
      check({name, " R5 valid later"}, out_valid, 0);
      return;
    end
    for (int i = 0; i < eff; i++) begin
      check({name, " R2 valid"}, out_valid, 1);
      check({name, " R3 data"}, out_data, exp_elem(m, i, s));
      if (i == 0) check({name, " R4 first"}, out_data, 0);
      check({name, " R2 last"}, out_last, (i == eff - 1) ? 1 : 0);
      check({name, " R7 total"}, out_total,
            (i == eff - 1) ? $countones(m & ~({MW{1'b1}} >> eff)) : 0);
      if (i > 0) check({name, " R9 step"}, out_data - (exp_elem(m, i - 1, s)),
                       m[MW-i] ? longint'(s) : 0);
      if (i == inject) begin
        mask_in = ~m; len_in = LW'(3); stride_in = s + SW'(1); start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check({name, " R2 ends"}, out_valid, 0);
    check({name, " R8 no rerun"}, busy, 0);
    @(negedge clk);
    check({name, " R8 idle"}, out_valid, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", out_valid, 0);
    check("R1 last", out_last, 0);
    check("R1 busy", busy, 0);
    check("R1 total", out_total, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("full s1", {MW{1'b1}}, 16, SW'(1), -1);
    run_case("alt s1", {(MW/2){2'b01}}, 12, SW'(1), -1);
    run_case("single s1", 64'h0800_0000_0000_0000, 9, SW'(1), -1);
    run_case("single s2", 64'h0800_0000_0000_0000, 9, SW'(2), -1);
    run_case("len0", {MW{1'b1}}, 0, SW'(5), -1);
    run_case("clamp R6", 64'hDEAD_BEEF_0123_4567, 200, SW'(3), -1);
    run_case("len1", 64'h8000_0000_0000_0000, 1, SW'(7), -1);
    run_case("wide stride", 64'hF0F0_0000_0000_000F, 64, SW'(16'hFFFF), -1);
    run_case("mid start R8", 64'hA5A5_0000_0000_0000, 10, SW'(4), 4);
    run_case("last start R8", 64'h3C00_0000_0000_0000, 8, SW'(6), 7);
    run_case("after busy", {(MW/2){2'b10}}, 6, SW'(9), -1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule